// File: doc/BRIEF.md
# LPDDR4 Read Deserializer with Slip Alignment and Valid Delay

This block sits on the read side of a memory PHY. Each system cycle it receives one group of sixteen DDR beats, already captured from the sixteen data lines, and repacks them into eight 32-bit phase words for the memory controller. The incoming beat stream is not guaranteed to start a burst on a system-cycle boundary. A slip setting from 0 to 15 beats picks which sixteen consecutive beats, taken across two adjacent groups, form one output word set. The capture path runs every cycle whether or not a read is outstanding.

On the control side, a read enable on any phase produces a valid flag on all eight phases a fixed number of system cycles later. The default latency is nine cycles, which includes one spare cycle so that a nonzero slip can still be absorbed.

Top module: `lpddr4_rd_deser`

## Requirements
- R1: While reset is low and in the first cycle after it, every bit of `rd_data_o` and `rd_valid_o` reads 0, and the slip setting is 0.
- R2: If any bit of `rd_en_i` is high at a clock edge in cycle n, all eight bits of `rd_valid_o` are high in cycle n+9. In every other cycle `rd_valid_o` is all zero.
- R3: The data path updates every cycle, independent of `rd_en_i`.
- R4: At slip 0, the group presented on `dq_grp_i` in cycle n appears unchanged on `rd_data_o` in cycle n+3.
- R5: Beat b of a group occupies bits [16b+15:16b] of `dq_grp_i`, with bit l of that field being data line l. Output phase p occupies bits [32p+31:32p] of `rd_data_o`. Its lower half is beat 2p and its upper half is beat 2p+1.
- R6: With slip s, output beat j in cycle n+3 is beat s+j of the 32-beat sequence formed by the group of cycle n followed by the group of cycle n+1.
- R7: Each cycle with `slip_bump_i` high raises the slip by one, and 15 wraps to 0. The new slip applies from the following cycle's output. Without a bump the slip holds.
- R8: Several enable phases set together in one cycle produce a single valid cycle. Enables in consecutive cycles produce valid in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dq_grp_i | input | 256 | Sixteen captured beats of sixteen data lines, beat 0 lowest and oldest |
| slip_bump_i | input | 1 | Advances the beat slip by one, wrapping |
| rd_en_i | input | 8 | Per-phase read enable from the controller |
| rd_data_o | output | 256 | Eight 32-bit read phase words |
| rd_valid_o | output | 8 | Per-phase read data valid |

## Verification
The properties take `rst_n` to be low on the first clock edge. They also take `slip_bump_i` and `rd_en_i` to be driven to known levels on every edge after reset. The bench holds reset for several cycles before releasing it, and it drives every input at the falling edge on each cycle, so no input is ever left unknown. Bump pulses are packed back to back through the wrap so that the 15-to-0 transition is crossed. Read enables come both isolated and adjacent so that the valid window gets exercised.

// File: rtl/lpddr4_rdes_pkg.sv
package lpddr4_rdes_pkg;
   parameter int unsigned DEF_LANES  = 16;
   parameter int unsigned DEF_BEATS  = 16;
   parameter int unsigned DEF_PHASES = 8;
   parameter int unsigned DEF_RD_LAT = 9;

   function automatic int unsigned slip_width(input int unsigned beats);
      return (beats > 1) ? $clog2(beats) : 1;
   endfunction
endpackage

// File: rtl/rdes_capture.sv
module rdes_capture #(
   parameter int unsigned GROUP_W = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GROUP_W-1:0] grp_i,
   output logic [GROUP_W-1:0] cur_o,
   output logic [GROUP_W-1:0] prev_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_o  <= '0;
         prev_o <= '0;
      end else begin
         cur_o  <= grp_i;
         prev_o <= cur_o;
      end
   end
endmodule

// File: rtl/rdes_slip_ctrl.sv
module rdes_slip_ctrl #(
   parameter int unsigned BEATS = 16,
   localparam int unsigned SW   = lpddr4_rdes_pkg::slip_width(BEATS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bump_i,
   output logic [SW-1:0] slip_o
);
   localparam logic [SW-1:0] TOP = SW'(BEATS - 1);
   logic [SW-1:0] nxt;

   generate
      if ((1 << SW) == BEATS) begin : g_pow2
         always_comb nxt = slip_o + 1'b1;
      end else begin : g_cmp
         always_comb nxt = (slip_o == TOP) ? '0 : slip_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      slip_o <= '0;
      else if (bump_i) slip_o <= nxt;
   end
endmodule

// File: rtl/rdes_window.sv
module rdes_window #(
   parameter int unsigned LANES = 16,
   parameter int unsigned BEATS = 16,
   localparam int unsigned GW   = LANES * BEATS,
   localparam int unsigned SW   = lpddr4_rdes_pkg::slip_width(BEATS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] cur_i,
   input  logic [GW-1:0] prev_i,
   input  logic [SW-1:0] slip_i,
   output logic [GW-1:0] word_o
);
   logic [2*GW-1:0] span;
   logic [GW-1:0]   pick;

   assign span = {cur_i, prev_i};

   generate
      for (genvar j = 0; j < BEATS; j++) begin : g_beat
         always_comb begin
            int idx;
            idx = int'(slip_i) + j;
            pick[j*LANES +: LANES] = span[idx*LANES +: LANES];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) word_o <= '0;
      else        word_o <= pick;
   end
endmodule

// File: rtl/rdes_valid_pipe.sv
module rdes_valid_pipe #(
   parameter int unsigned PHASES = 8,
   parameter int unsigned LAT    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHASES-1:0] en_i,
   output logic [PHASES-1:0] valid_o
);
   logic any_en;
   logic tail;
   assign any_en = |en_i;

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) tail <= 1'b0;
            else        tail <= any_en;
         end
      end else begin : g_chain
         logic [LAT-1:0] stages;
         always_ff @(posedge clk) begin
            if (!rst_n) stages <= '0;
            else        stages <= {stages[LAT-2:0], any_en};
         end
         assign tail = stages[LAT-1];
      end
   endgenerate

   assign valid_o = {PHASES{tail}};
endmodule

// File: rtl/lpddr4_rd_deser.sv
module lpddr4_rd_deser #(
   parameter int unsigned LANES  = lpddr4_rdes_pkg::DEF_LANES,
   parameter int unsigned BEATS  = lpddr4_rdes_pkg::DEF_BEATS,
   parameter int unsigned PHASES = lpddr4_rdes_pkg::DEF_PHASES,
   parameter int unsigned RD_LAT = lpddr4_rdes_pkg::DEF_RD_LAT,
   localparam int unsigned GW    = LANES * BEATS,
   localparam int unsigned SW    = lpddr4_rdes_pkg::slip_width(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GW-1:0]     dq_grp_i,
   input  logic              slip_bump_i,
   input  logic [PHASES-1:0] rd_en_i,
   output logic [GW-1:0]     rd_data_o,
   output logic [PHASES-1:0] rd_valid_o
);
   generate
      if (BEATS != 2 * PHASES) begin : g_bad_ratio
         $error("BEATS must equal twice PHASES");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   logic [GW-1:0] cur_q, prev_q;
   logic [SW-1:0] slip_q;

   rdes_capture #(.GROUP_W(GW)) u_cap (
      .clk(clk), .rst_n(rst_n), .grp_i(dq_grp_i),
      .cur_o(cur_q), .prev_o(prev_q)
   );

   rdes_slip_ctrl #(.BEATS(BEATS)) u_slip (
      .clk(clk), .rst_n(rst_n), .bump_i(slip_bump_i), .slip_o(slip_q)
   );

   rdes_window #(.LANES(LANES), .BEATS(BEATS)) u_win (
      .clk(clk), .rst_n(rst_n), .cur_i(cur_q), .prev_i(prev_q),
      .slip_i(slip_q), .word_o(rd_data_o)
   );

   rdes_valid_pipe #(.PHASES(PHASES), .LAT(RD_LAT)) u_vld (
      .clk(clk), .rst_n(rst_n), .en_i(rd_en_i), .valid_o(rd_valid_o)
   );
endmodule

// File: rtl/rdes_checker.sv
module rdes_checker #(
   parameter int unsigned PHASES = 8,
   parameter int unsigned LAT    = 9,
   parameter int unsigned BEATS  = 16,
   parameter int unsigned SW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PHASES-1:0] rd_en,
   input logic [PHASES-1:0] rd_valid,
   input logic              bump,
   input logic [SW-1:0]     slip
);
   logic [LAT-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else begin
         for (int i = LAT - 1; i > 0; i--) seen[i] <= seen[i-1];
         seen[0] <= |rd_en;
      end
   end

   // R2: valid follows the OR of enables after the full latency, on all phases
   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == {PHASES{seen[LAT-1]}});

   // R2: the phases of valid always agree
   p_valid_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid == '0) || (rd_valid == '1));

   // R7: wrap from the top setting
   p_slip_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && slip == SW'(BEATS - 1)) |=> (slip == '0));

   // R7: single step below the top
   p_slip_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && slip != SW'(BEATS - 1)) |=> (slip == SW'($past(slip) + 1'b1)));

   // R7: no bump, no change
   p_slip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bump |=> $stable(slip));
endmodule

bind lpddr4_rd_deser rdes_checker #(
   .PHASES(PHASES), .LAT(RD_LAT), .BEATS(BEATS), .SW(SW)
) u_rdes_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .rd_valid(rd_valid_o),
   .bump(slip_bump_i), .slip(slip_q)
);

// File: tb/lpddr4_rd_deser_test.sv
`timescale 1ns/1ps
module lpddr4_rd_deser_test;
   localparam int GW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [GW-1:0] grp = '0;
   logic          bump = 1'b0;
   logic [7:0]    en = '0;
   logic [GW-1:0] rd_data;
   logic [7:0]    rd_valid;

   int checks = 0;
   int errors = 0;

   logic [GW-1:0] in_hist[$];
   bit            en_hist[$];
   int            slip_m = 0;

   always #2.5 clk = ~clk;

   lpddr4_rd_deser uut (
      .clk(clk), .rst_n(rst_n), .dq_grp_i(grp), .slip_bump_i(bump),
      .rd_en_i(en), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
   );

   task automatic chk(input string req, input logic [GW-1:0] act, input logic [GW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [GW-1:0] rnd();
      logic [GW-1:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   // R5/R6 reference: beats of prev then cur, take 16 starting at s
   function automatic logic [GW-1:0] expect_word(input logic [GW-1:0] p,
                                                 input logic [GW-1:0] c, input int s);
      logic [GW-1:0] o;
      for (int j = 0; j < 16; j++) begin
         for (int l = 0; l < 16; l++) begin
            if (s + j < 16) o[j*16 + l] = p[(s + j)*16 + l];
            else            o[j*16 + l] = c[(s + j - 16)*16 + l];
         end
      end
      return o;
   endfunction

   // called at a falling edge; drives, runs one edge, compares at next falling edge
   task automatic step(input logic [GW-1:0] g, input bit b, input logic [7:0] e,
                       input string dtag, input string vtag);
      logic [GW-1:0] pv, cv, ed;
      logic [7:0]    ev;
      int n, m;
      grp = g; bump = b; en = e;
      @(posedge clk);
      n  = in_hist.size();
      pv = (n >= 2) ? in_hist[n-2] : '0;
      cv = (n >= 1) ? in_hist[n-1] : '0;
      ed = expect_word(pv, cv, slip_m);
      m  = en_hist.size();
      ev = (m >= 8 && en_hist[m-8]) ? 8'hFF : 8'h00;
      in_hist.push_back(g);
      en_hist.push_back(|e);
      if (b) slip_m = (slip_m + 1) % 16;
      @(negedge clk);
      chk(dtag, rd_data, ed);
      chk(vtag, GW'(rd_valid), GW'(ev));
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [GW-1:0] pat;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1", rd_data, '0);
      chk("R1", GW'(rd_valid), '0);
      rst_n = 1'b1;

      // R3/R4: data moves with no read enable, slip 0
      for (int i = 0; i < 20; i++) step(rnd(), 1'b0, 8'h00, "R4", "R3");

      // R2: single phase enable, exact delay
      step(rnd(), 1'b0, 8'h04, "R3", "R2");
      for (int i = 0; i < 12; i++) step(rnd(), 1'b0, 8'h00, "R3", "R2");

      // R8: many phases at once, then back to back
      step(rnd(), 1'b0, 8'hA5, "R3", "R8");
      step(rnd(), 1'b0, 8'h00, "R3", "R8");
      step(rnd(), 1'b0, 8'h01, "R3", "R8");
      step(rnd(), 1'b0, 8'h80, "R3", "R8");
      for (int i = 0; i < 12; i++) step(rnd(), 1'b0, 8'h00, "R3", "R8");

      // R6: slip 1, then 4
      step(rnd(), 1'b1, 8'h00, "R6", "R2");
      for (int i = 0; i < 6; i++) step(rnd(), 1'b0, 8'h00, "R6", "R2");
      for (int i = 0; i < 3; i++) step(rnd(), 1'b1, 8'h00, "R6", "R2");
      for (int i = 0; i < 6; i++) step(rnd(), 1'b0, 8'h10, "R6", "R2");

      // R7: twelve bumps in a row wrap 4 -> 0 through 15
      for (int i = 0; i < 12; i++) step(rnd(), 1'b1, 8'h00, "R7", "R2");
      for (int i = 0; i < 10; i++) step(rnd(), 1'b0, 8'h00, "R7", "R2");

      // R5: directed packing check, beat b carries nibble b on every line
      for (int b = 0; b < 16; b++) pat[b*16 +: 16] = {4{4'(b)}};
      step(pat, 1'b0, 8'h00, "R5", "R2");
      step('0, 1'b0, 8'h00, "R5", "R2");
      step('0, 1'b0, 8'h00, "R5", "R2");
      chk("R5", GW'(rd_data[3*32 +: 32]), GW'(32'h7777_6666));
      chk("R5", GW'(rd_data[0 +: 32]), GW'(32'h1111_0000));
      for (int i = 0; i < 10; i++) step(rnd(), 1'b0, 8'h00, "R4", "R2");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule